// File: doc/BRIEF.md
# SDRAM Command Decoder and Sequencing Checker

This block watches the control lines of a four-bank single-data-rate SDRAM. It samples them on every rising clock edge, names the command that was issued, and reports the bank it targets and whether automatic precharge was requested. It also keeps a small model of the device: which banks have an open row, whether a data burst is running, and how long it has been since a mode-register write or an automatic precharge. When the controller it watches breaks a sequencing rule, the block raises a one-cycle violation with a reason code and keeps decoding.

Besides the command view, the block produces two data-mask views. One tells whether the write beat on the current edge is masked. The other tells whether the read data for the current edge must be left undriven because of a mask sampled two edges earlier. All outputs are registered. The values visible after edge n describe the command and data beat sampled at edge n.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With clock enable high at both the previous and the current edge, and chip select low, the strobes {ras, cas, we} (low active) decode as 000 mode set (code 1), 001 refresh (2), 011 activate (3), 101 read (4), 100 write (5), 110 burst stop (6), 010 precharge (7) and 111 no-operation (0). Chip select high decodes as no-operation (0).
- R2: Clock enable falling with chip select low and the refresh strobes decodes as self-refresh entry (8). Clock enable rising while in self refresh decodes as self-refresh exit (9). Every other edge where clock enable is low at the previous or the current edge decodes as suspend (10).
- R3: The bank index is 2*BA0 + BA1. It is reported on cmdBank for activate, read, write and single-bank precharge, and is 0 for every other command.
- R4: autoPre is 1 only for a read or write sampled with the auto-precharge line high. A precharge with that line high closes all four banks, ignores the bank inputs and reports bank 0.
- R5: A mode set while any bank is open is flagged with reason 1. A refresh or self-refresh entry while any bank is open is flagged with reason 2.
- R6: On the two edges that follow an accepted mode set, any command other than no-operation is flagged with reason 3. This check takes priority over every other reason.
- R7: The burst length is 1, 2, 4 or 8, selected by address bits [1:0] = 0..3 at an accepted mode set. A read or write issued while an auto-precharge burst still has beats left (its last beat included) is flagged with reason 4.
- R8: When an auto-precharge burst ends at edge L, its bank closes. An activate to that bank at an edge before L+TRP is flagged with reason 5 (default TRP = 3).
- R9: An activate to an open bank, or a read or write to a closed bank, is flagged with reason 6.
- R10: An accepted burst stop ends the running burst. If that burst had automatic precharge, its bank closes at the stop edge and the TRP wait counts from that edge.
- R11: wrMask after edge n is 1 when the data mask was high at edge n and edge n carried a write beat (an accepted write, or a running write burst not ended by an accepted read or burst stop).
- R12: rdHiZ after edge n equals the data mask sampled at edge n-2.
- R13: After reset all banks are closed, no burst runs, the burst length is 1 and all outputs are 0. A violation lasts one cycle with a nonzero reason (0 otherwise), and a flagged command leaves the bank, burst and mode state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, rising edge samples |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable |
| csN | input | 1 | Chip select, low active |
| rasN | input | 1 | Row strobe, low active |
| casN | input | 1 | Column strobe, low active |
| weN | input | 1 | Write enable, low active |
| ba | input | 2 | Bank address lines, ba[0] is the high index bit |
| addrAp | input | 1 | Auto-precharge / all-bank address line |
| addrLow | input | 2 | Low address lines, burst length code at mode set |
| dqm | input | 1 | Data mask |
| cmdCode | output | 4 | Decoded command code |
| cmdBank | output | 2 | Target bank index |
| autoPre | output | 1 | Read or write with automatic precharge |
| violation | output | 1 | One-cycle rule violation pulse |
| reason | output | 3 | Violation reason code, 0 when none |
| wrMask | output | 1 | Write beat at this edge is masked |
| rdHiZ | output | 1 | Read data at this edge left undriven |

## Verification
The assertions check relations that hold on every cycle from the ports alone. They check that a violation always comes with a nonzero reason, that the two edges after an accepted mode set carry only no-operation or are flagged, that the auto-precharge flag and bank field appear only with commands that carry them, that self-refresh exit follows a clock-enable rise, and that both masks trace back to the data-mask input at the right distance. Bank state and burst timing are internal, so only the bench's scenarios can show them: reads of banks closed by an all-bank precharge, the TRP window after an auto-precharge burst or burst stop, rejected commands that leave state untouched, and write masking that ends exactly when the burst does.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;
  localparam int NUM_BANKS   = 4;
  localparam int BANK_W      = $clog2(NUM_BANKS);
  localparam int MAX_BURST   = 8;
  localparam int BURST_W     = $clog2(MAX_BURST);
  localparam int MODE_GAP    = 2;
  localparam int GAP_W       = $clog2(MODE_GAP + 1);
  localparam int RD_MASK_LAT = 2;

  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_MRS   = 4'd1,
    CMD_REF   = 4'd2,
    CMD_ACT   = 4'd3,
    CMD_RD    = 4'd4,
    CMD_WR    = 4'd5,
    CMD_BST   = 4'd6,
    CMD_PRE   = 4'd7,
    CMD_SRIN  = 4'd8,
    CMD_SROUT = 4'd9,
    CMD_SUSP  = 4'd10
  } cmdE;

  typedef enum logic [2:0] {
    RSN_NONE     = 3'd0,
    RSN_MRS_BUSY = 3'd1,
    RSN_REF_BUSY = 3'd2,
    RSN_MRS_GAP  = 3'd3,
    RSN_AP_BURST = 3'd4,
    RSN_TRP      = 3'd5,
    RSN_BANK     = 3'd6
  } rsnE;

  typedef struct packed {
    logic loadMode;
    logic writeBeat;
  } strobeT;
endpackage

// File: rtl/sdram_mon_dpath.sv
module sdram_mon_dpath
  import sdram_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dqm,
  input  logic [1:0] modeBits,
  input  strobeT     strb,
  output logic [1:0] blCode,
  output logic       wrMask,
  output logic       rdHiZ
);
  localparam int STAGES = RD_MASK_LAT + 1;

  logic [STAGES-1:0] hizPipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      blCode <= 2'd0;
      wrMask <= 1'b0;
    end else begin
      if (strb.loadMode) blCode <= modeBits;
      wrMask <= dqm & strb.writeBeat;
    end
  end

  // Read mask delay line: one stage per edge of latency, plus the output register.
  for (genvar s = 0; s < STAGES; s++) begin : g_hiz
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) hizPipe[0] <= 1'b0;
        else     hizPipe[0] <= dqm;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) hizPipe[s] <= 1'b0;
        else     hizPipe[s] <= hizPipe[s-1];
      end
    end
  end

  assign rdHiZ = hizPipe[STAGES-1];
endmodule

// File: rtl/sdram_mon_ctrl.sv
module sdram_mon_ctrl
  import sdram_mon_pkg::*;
#(
  parameter int TRP = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [1:0]        ba,
  input  logic              apBit,
  input  logic [1:0]        blCode,
  output strobeT            strb,
  output logic [3:0]        cmdCode,
  output logic [BANK_W-1:0] cmdBank,
  output logic              autoPre,
  output logic              violation,
  output logic [2:0]        reason
);
  localparam int PW = $clog2(TRP + 1);
  localparam logic [PW-1:0] PRE_LOAD = PW'(TRP - 1);

  logic                 ckePrev, selfRef;
  logic [GAP_W-1:0]     modeWait;
  logic [NUM_BANKS-1:0] bankOpen;
  logic [PW-1:0]        preCnt [NUM_BANKS];
  logic [BURST_W-1:0]   burstLeft;
  logic [BANK_W-1:0]    burstBank;
  logic                 burstAp, burstWr;

  cmdE               cmdNext;
  rsnE               rsn;
  logic [BANK_W-1:0] bankIdx;
  logic [3:0]        blLen;
  logic [BURST_W-1:0] blLast;
  logic              accept, apBusy;

  assign bankIdx = {ba[0], ba[1]};
  assign blLen   = 4'd1 << blCode;
  assign blLast  = BURST_W'(blLen - 4'd1);
  assign apBusy  = (burstLeft != '0) && burstAp;

  always_comb begin
    cmdNext = CMD_SUSP;
    if (ckePrev && cke) begin
      if (csN) cmdNext = CMD_NOP;
      else begin
        case ({rasN, casN, weN})
          3'b000:  cmdNext = CMD_MRS;
          3'b001:  cmdNext = CMD_REF;
          3'b011:  cmdNext = CMD_ACT;
          3'b101:  cmdNext = CMD_RD;
          3'b100:  cmdNext = CMD_WR;
          3'b110:  cmdNext = CMD_BST;
          3'b010:  cmdNext = CMD_PRE;
          default: cmdNext = CMD_NOP;
        endcase
      end
    end else if (ckePrev && !cke) begin
      if (!csN && {rasN, casN, weN} == 3'b001) cmdNext = CMD_SRIN;
    end else if (!ckePrev && cke && selfRef) begin
      cmdNext = CMD_SROUT;
    end
  end

  always_comb begin
    rsn = RSN_NONE;
    if (modeWait != '0 && cmdNext != CMD_NOP) rsn = RSN_MRS_GAP;
    else begin
      case (cmdNext)
        CMD_MRS:           if (|bankOpen) rsn = RSN_MRS_BUSY;
        CMD_REF, CMD_SRIN: if (|bankOpen) rsn = RSN_REF_BUSY;
        CMD_RD, CMD_WR: begin
          if (apBusy)                 rsn = RSN_AP_BURST;
          else if (!bankOpen[bankIdx]) rsn = RSN_BANK;
        end
        CMD_ACT: begin
          if (bankOpen[bankIdx])          rsn = RSN_BANK;
          else if (preCnt[bankIdx] != '0) rsn = RSN_TRP;
        end
        default: rsn = RSN_NONE;
      endcase
    end
  end

  assign accept         = (rsn == RSN_NONE);
  assign strb.loadMode  = accept && (cmdNext == CMD_MRS);
  assign strb.writeBeat = (accept && cmdNext == CMD_WR) ||
                          ((burstLeft != '0) && burstWr &&
                           !(accept && (cmdNext == CMD_RD || cmdNext == CMD_BST)));

  always_ff @(posedge clk) begin
    if (rst) begin
      ckePrev   <= 1'b1;
      selfRef   <= 1'b0;
      modeWait  <= '0;
      bankOpen  <= '0;
      for (int b = 0; b < NUM_BANKS; b++) preCnt[b] <= '0;
      burstLeft <= '0;
      burstBank <= '0;
      burstAp   <= 1'b0;
      burstWr   <= 1'b0;
      cmdCode   <= CMD_NOP;
      cmdBank   <= '0;
      autoPre   <= 1'b0;
      violation <= 1'b0;
      reason    <= RSN_NONE;
    end else begin
      ckePrev <= cke;
      for (int b = 0; b < NUM_BANKS; b++)
        if (preCnt[b] != '0) preCnt[b] <= preCnt[b] - PW'(1);
      if (modeWait != '0) modeWait <= modeWait - GAP_W'(1);

      if (burstLeft != '0) begin
        burstLeft <= burstLeft - BURST_W'(1);
        if (burstLeft == BURST_W'(1) && burstAp) begin
          bankOpen[burstBank] <= 1'b0;
          preCnt[burstBank]   <= PRE_LOAD;
        end
      end

      if (accept) begin
        case (cmdNext)
          CMD_MRS:   modeWait <= GAP_W'(MODE_GAP);
          CMD_SRIN:  selfRef  <= 1'b1;
          CMD_SROUT: selfRef  <= 1'b0;
          CMD_ACT:   bankOpen[bankIdx] <= 1'b1;
          CMD_PRE: begin
            if (apBit) bankOpen <= '0;
            else       bankOpen[bankIdx] <= 1'b0;
          end
          CMD_RD, CMD_WR: begin
            burstLeft <= blLast;
            burstBank <= bankIdx;
            burstAp   <= apBit;
            burstWr   <= (cmdNext == CMD_WR);
            if (blLast == '0 && apBit) begin
              bankOpen[bankIdx] <= 1'b0;
              preCnt[bankIdx]   <= PRE_LOAD;
            end
          end
          CMD_BST: begin
            if (burstLeft != '0) begin
              burstLeft <= '0;
              if (burstAp) begin
                bankOpen[burstBank] <= 1'b0;
                preCnt[burstBank]   <= PRE_LOAD;
              end
            end
          end
          default: ;
        endcase
      end

      cmdCode   <= cmdNext;
      cmdBank   <= (cmdNext == CMD_ACT || cmdNext == CMD_RD || cmdNext == CMD_WR ||
                    (cmdNext == CMD_PRE && !apBit)) ? bankIdx : '0;
      autoPre   <= (cmdNext == CMD_RD || cmdNext == CMD_WR) && apBit;
      violation <= !accept;
      reason    <= rsn;
    end
  end
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int TRP = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cke,
  input  logic       csN,
  input  logic       rasN,
  input  logic       casN,
  input  logic       weN,
  input  logic [1:0] ba,
  input  logic       addrAp,
  input  logic [1:0] addrLow,
  input  logic       dqm,
  output logic [3:0] cmdCode,
  output logic [1:0] cmdBank,
  output logic       autoPre,
  output logic       violation,
  output logic [2:0] reason,
  output logic       wrMask,
  output logic       rdHiZ
);
  strobeT     strb;
  logic [1:0] blCode;

  sdram_mon_ctrl #(.TRP(TRP)) ctrl_i (
    .clk(clk), .rst(rst), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .apBit(addrAp), .blCode(blCode), .strb(strb),
    .cmdCode(cmdCode), .cmdBank(cmdBank), .autoPre(autoPre),
    .violation(violation), .reason(reason)
  );

  sdram_mon_dpath dpath_i (
    .clk(clk), .rst(rst), .dqm(dqm), .modeBits(addrLow), .strb(strb),
    .blCode(blCode), .wrMask(wrMask), .rdHiZ(rdHiZ)
  );
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk
  import sdram_mon_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cke,
  input logic       dqm,
  input logic [3:0] cmdCode,
  input logic [1:0] cmdBank,
  input logic       autoPre,
  input logic       violation,
  input logic [2:0] reason,
  input logic       wrMask,
  input logic       rdHiZ
);
  p_reason_pair_r13: assert property (@(posedge clk) disable iff (rst)
    violation == (reason != 3'd0));

  p_mode_gap1_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(cmdCode == CMD_MRS && !violation) && cmdCode != CMD_NOP) |-> violation);

  p_mode_gap2_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(cmdCode == CMD_MRS && !violation, 2) && cmdCode != CMD_NOP) |-> violation);

  p_ap_only_rw_r4: assert property (@(posedge clk) disable iff (rst)
    autoPre |-> (cmdCode == CMD_RD || cmdCode == CMD_WR));

  p_bank_field_r3: assert property (@(posedge clk) disable iff (rst)
    (cmdCode != CMD_ACT && cmdCode != CMD_RD && cmdCode != CMD_WR && cmdCode != CMD_PRE)
      |-> cmdBank == 2'd0);

  p_sr_exit_r2: assert property (@(posedge clk) disable iff (rst)
    (cmdCode == CMD_SROUT) |-> ($past(cke) && !$past(cke, 2)));

  p_wr_mask_r11: assert property (@(posedge clk) disable iff (rst)
    wrMask |-> $past(dqm));

  p_rd_hiz_r12: assert property (@(posedge clk) disable iff (rst)
    rdHiZ |-> $past(dqm, 3));
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk chk_i (.*);

// File: tb/sdram_cmd_monitor_tb_top.sv
module sdram_cmd_monitor_tb_top;
  localparam int TRP = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0] ba = 2'd0, addrLow = 2'd0;
  logic addrAp = 1'b0, dqm = 1'b0;
  logic [3:0] cmdCode;
  logic [1:0] cmdBank;
  logic autoPre, violation, wrMask, rdHiZ;
  logic [2:0] reason;

  always #10ns clk = ~clk;

  sdram_cmd_monitor #(.TRP(TRP)) dut_i (
    .clk(clk), .rst(rst), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addrAp(addrAp), .addrLow(addrLow), .dqm(dqm),
    .cmdCode(cmdCode), .cmdBank(cmdBank), .autoPre(autoPre),
    .violation(violation), .reason(reason), .wrMask(wrMask), .rdHiZ(rdHiZ)
  );

  int nChk = 0, nFail = 0;
  bit finished = 0;
  string curReq = "R1";
  logic gCke = 1'b1, gDqm = 1'b0;

  // Reference model state
  int mOpen[4], mPre[4];
  int mLeft, mBank, mAp, mWr, mBl, mWait, mCkeP, mSelf;
  int hist[$];
  int eCmd, eBank, eAp, eViol, eRsn, eMask, eHiz;

  task automatic modelReset();
    for (int b = 0; b < 4; b++) begin mOpen[b] = 0; mPre[b] = 0; end
    mLeft = 0; mBank = 0; mAp = 0; mWr = 0; mBl = 1; mWait = 0; mCkeP = 1; mSelf = 0;
    hist = {0, 0};
    eCmd = 0; eBank = 0; eAp = 0; eViol = 0; eRsn = 0; eMask = 0; eHiz = 0;
  endtask

  task automatic closeBank(input int b);
    mOpen[b] = 0;
    mPre[b]  = TRP - 1;
  endtask

  task automatic modelStep();
    int cmd, idx, rsn, wb, ok, anyOpen;
    idx = ba[0] * 2 + ba[1];
    cmd = 10;
    if (mCkeP == 1 && cke) begin
      if (csN) cmd = 0;
      else if (!rasN && !casN && !weN) cmd = 1;
      else if (!rasN && !casN && weN)  cmd = 2;
      else if (!rasN && casN && weN)   cmd = 3;
      else if (rasN && !casN && weN)   cmd = 4;
      else if (rasN && !casN && !weN)  cmd = 5;
      else if (rasN && casN && !weN)   cmd = 6;
      else if (!rasN && casN && !weN)  cmd = 7;
      else cmd = 0;
    end else if (mCkeP == 1 && !cke) begin
      if (!csN && !rasN && !casN && weN) cmd = 8;
    end else if (mCkeP == 0 && cke && mSelf == 1) cmd = 9;

    anyOpen = mOpen[0] | mOpen[1] | mOpen[2] | mOpen[3];
    rsn = 0;
    if (mWait > 0 && cmd != 0) rsn = 3;
    else if (cmd == 1 && anyOpen != 0) rsn = 1;
    else if ((cmd == 2 || cmd == 8) && anyOpen != 0) rsn = 2;
    else if (cmd == 4 || cmd == 5) begin
      if (mLeft > 0 && mAp == 1) rsn = 4;
      else if (mOpen[idx] == 0) rsn = 6;
    end else if (cmd == 3) begin
      if (mOpen[idx] == 1) rsn = 6;
      else if (mPre[idx] > 0) rsn = 5;
    end
    ok = (rsn == 0);
    wb = (ok && cmd == 5) || (mLeft > 0 && mWr == 1 && !(ok && (cmd == 4 || cmd == 6)));

    for (int b = 0; b < 4; b++) if (mPre[b] > 0) mPre[b]--;
    if (mWait > 0) mWait--;
    if (mLeft > 0) begin
      if (mLeft == 1 && mAp == 1) closeBank(mBank);
      mLeft--;
    end
    if (ok) begin
      case (cmd)
        1: begin mWait = 2; mBl = 1 << addrLow; end
        8: mSelf = 1;
        9: mSelf = 0;
        3: mOpen[idx] = 1;
        7: if (addrAp) for (int b = 0; b < 4; b++) mOpen[b] = 0; else mOpen[idx] = 0;
        4, 5: begin
          mLeft = mBl - 1; mBank = idx; mAp = addrAp; mWr = (cmd == 5);
          if (mBl == 1 && addrAp) closeBank(idx);
        end
        6: if (mLeft > 0) begin
          if (mAp == 1) closeBank(mBank);
          mLeft = 0;
        end
        default: ;
      endcase
    end
    mCkeP = cke;

    eCmd  = cmd;
    eBank = (cmd == 3 || cmd == 4 || cmd == 5 || (cmd == 7 && !addrAp)) ? idx : 0;
    eAp   = ((cmd == 4 || cmd == 5) && addrAp) ? 1 : 0;
    eViol = ok ? 0 : 1;
    eRsn  = rsn;
    eMask = (dqm && wb) ? 1 : 0;
    hist.push_back(int'(dqm));
    eHiz  = hist.pop_front();
  endtask

  task automatic chk(input bit good, input string req, input string what,
                     input int act, input int exp);
    nChk++;
    if (!good) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk(int'(cmdCode) == eCmd, curReq, "cmdCode", int'(cmdCode), eCmd);
    chk(int'(cmdBank) == eBank, curReq, "cmdBank", int'(cmdBank), eBank);
    chk(int'(autoPre) == eAp, curReq, "autoPre", int'(autoPre), eAp);
    chk(int'(violation) == eViol, curReq, "violation", int'(violation), eViol);
    chk(int'(reason) == eRsn, curReq, "reason", int'(reason), eRsn);
    chk(int'(wrMask) == eMask, "R11", "wrMask", int'(wrMask), eMask);
    chk(int'(rdHiZ) == eHiz, "R12", "rdHiZ", int'(rdHiZ), eHiz);
  endtask

  task automatic step(input logic c, input logic s, input logic r, input logic a,
                      input logic w, input int bank, input logic ap, input logic [1:0] lo);
    cke = c; csN = s; rasN = r; casN = a; weN = w;
    ba = {bank[0], bank[1]};
    addrAp = ap; addrLow = lo; dqm = gDqm;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic nop();              step(gCke, 0, 1, 1, 1, 0, 0, 2'd0); endtask
  task automatic dsel();             step(gCke, 1, 0, 0, 0, 3, 1, 2'd3); endtask
  task automatic mrs(input logic [1:0] lo); step(1, 0, 0, 0, 0, 0, 0, lo); endtask
  task automatic refr();             step(1, 0, 0, 0, 1, 0, 0, 2'd0); endtask
  task automatic srEnter();          step(0, 0, 0, 0, 1, 0, 0, 2'd0); endtask
  task automatic act(input int b);   step(1, 0, 0, 1, 1, b, 0, 2'd0); endtask
  task automatic rd(input int b, input logic ap); step(1, 0, 1, 0, 1, b, ap, 2'd0); endtask
  task automatic wr(input int b, input logic ap); step(1, 0, 1, 0, 0, b, ap, 2'd0); endtask
  task automatic bst();              step(1, 0, 1, 1, 0, 0, 0, 2'd0); endtask
  task automatic pre(input int b, input logic all); step(1, 0, 0, 1, 0, b, all, 2'd0); endtask

  task automatic wantRsn(input int exp, input string req);
    chk(int'(reason) == exp, req, "reason", int'(reason), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++; nChk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R13: reset state
    chk(cmdCode == 4'd0 && cmdBank == 2'd0 && !autoPre && !violation &&
        reason == 3'd0 && !wrMask && !rdHiZ, "R13", "reset outputs",
        int'({cmdCode, violation, reason, wrMask, rdHiZ}), 0);

    // R1: decode table
    curReq = "R1";
    mrs(2'd2); chk(cmdCode == 4'd1, "R1", "mode set", int'(cmdCode), 1);
    nop(); nop(); dsel(); chk(cmdCode == 4'd0, "R1", "deselect", int'(cmdCode), 0);
    act(0); chk(cmdCode == 4'd3, "R1", "activate", int'(cmdCode), 3);
    rd(0, 0); chk(cmdCode == 4'd4, "R1", "read", int'(cmdCode), 4);
    nop(); nop(); nop();
    wr(0, 0); chk(cmdCode == 4'd5, "R1", "write", int'(cmdCode), 5);
    bst(); chk(cmdCode == 4'd6, "R1", "burst stop", int'(cmdCode), 6);
    pre(0, 0); chk(cmdCode == 4'd7, "R1", "precharge", int'(cmdCode), 7);
    refr(); chk(cmdCode == 4'd2 && !violation, "R1", "refresh", int'(cmdCode), 2);

    // R3: bank index order
    curReq = "R3";
    act(1); chk(cmdBank == 2'd1 && ba == 2'b10, "R3", "bank B pins", int'(cmdBank), 1);
    act(2); chk(cmdBank == 2'd2, "R3", "bank C", int'(cmdBank), 2);
    act(3); act(0);

    // R5: mode set / refresh with open banks
    curReq = "R5";
    mrs(2'd0); wantRsn(1, "R5");
    refr(); wantRsn(2, "R5");
    srEnter(); wantRsn(2, "R5");
    gCke = 1'b0; nop(); gCke = 1'b1; nop();
    chk(cmdCode == 4'd10, "R5", "suspend after rejected entry", int'(cmdCode), 10);
    pre(0, 1);

    // R6: wait after mode set
    curReq = "R6";
    mrs(2'd2); act(0); wantRsn(3, "R6");
    nop(); act(0); wantRsn(0, "R6");
    pre(0, 0);

    // R13: rejected command changes nothing
    curReq = "R13";
    mrs(2'd2); act(1); wantRsn(3, "R13");
    nop(); rd(1, 0); wantRsn(6, "R13");

    // R7 and R8: auto-precharge burst, then tRP window
    curReq = "R7";
    act(2); rd(2, 1);
    chk(autoPre == 1'b1, "R4", "autoPre on read", int'(autoPre), 1);
    rd(2, 0); wantRsn(4, "R7");
    nop(); wr(2, 0); wantRsn(4, "R7");
    curReq = "R8";
    act(2); wantRsn(5, "R8");
    act(2); wantRsn(5, "R8");
    act(2); wantRsn(0, "R8");
    pre(0, 1);

    // R11: write masking over an 8-beat burst
    curReq = "R11";
    mrs(2'd3); nop(); nop(); act(1);
    gDqm = 1'b1; wr(1, 0);
    chk(wrMask == 1'b1, "R11", "masked first beat", int'(wrMask), 1);
    for (int k = 0; k < 7; k++) begin gDqm = k[0]; nop(); end
    gDqm = 1'b1; nop();
    chk(wrMask == 1'b0, "R11", "after burst", int'(wrMask), 0);
    gDqm = 1'b0;

    // R10: burst stop
    curReq = "R10";
    mrs(2'd2); wantRsn(1, "R10");
    pre(0, 1); mrs(2'd2); nop(); nop();
    act(1); gDqm = 1'b1; wr(1, 0); bst();
    chk(wrMask == 1'b0, "R10", "stop ends write beats", int'(wrMask), 0);
    nop(); gDqm = 1'b0;
    act(3); rd(3, 1); bst();
    act(3); wantRsn(5, "R10");
    act(3); wantRsn(5, "R10");
    act(3); wantRsn(0, "R10");

    // R9: bank state rules
    curReq = "R9";
    pre(0, 1);
    rd(0, 0); wantRsn(6, "R9");
    act(0); act(0); wantRsn(6, "R9");
    pre(0, 0); wr(0, 0); wantRsn(6, "R9");

    // R4: all-bank precharge
    curReq = "R4";
    act(0); act(1); rd(1, 1);
    nop(); nop(); nop(); nop();
    act(0); wantRsn(6, "R4");
    pre(3, 1); chk(cmdBank == 2'd0, "R4", "all-bank bank field", int'(cmdBank), 0);
    rd(0, 0); wantRsn(6, "R4");

    // R12: read mask latency
    curReq = "R12";
    gDqm = 1'b1; nop(); gDqm = 1'b0; nop();
    chk(rdHiZ == 1'b0, "R12", "one edge later", int'(rdHiZ), 0);
    nop(); chk(rdHiZ == 1'b1, "R12", "two edges later", int'(rdHiZ), 1);
    nop(); chk(rdHiZ == 1'b0, "R12", "three edges later", int'(rdHiZ), 0);

    // R2: self refresh and suspend
    curReq = "R2";
    srEnter(); chk(cmdCode == 4'd8, "R2", "self-refresh entry", int'(cmdCode), 8);
    gCke = 1'b0; nop(); nop();
    chk(cmdCode == 4'd10, "R2", "held low", int'(cmdCode), 10);
    gCke = 1'b1; nop();
    chk(cmdCode == 4'd9, "R2", "self-refresh exit", int'(cmdCode), 9);
    nop();
    gCke = 1'b0; nop(); gCke = 1'b1; nop();
    chk(cmdCode == 4'd10, "R2", "power-down exit", int'(cmdCode), 10);
    nop(); nop();

    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule